// File: doc/BRIEF.md
# Five-Stage Pipeline Interlock Controller

This block decides, every cycle, whether an in-order pipeline with the stages Fetch, Decode, ALU, LS1 and LS2 may advance. It takes the register fields of the instruction sitting in Decode and keeps its own record of the destination, write, load and narrow-load flags of the instructions that have moved on into ALU, LS1 and LS2. From these it drives advance enables for Fetch and Decode, a bubble request for the ALU stage, one forwarding select per source operand, and flush strobes for the two front stages when a taken branch resolves in ALU.

Results become ready at different depths. An ordinary ALU result is ready in ALU. A full-word load is ready once it reaches LS1. A byte or halfword load is ready only in LS2, after its value has been extracted and extended. A consumer that reaches Decode too early is held there and a bubble goes into ALU until the producer is deep enough to be forwarded. Operations that need several ALU cycles report a remaining-cycle count. The controller freezes ALU and the stages in front of it until that count reaches one. The datapath, memory, register file and condition evaluation live outside this block.

Top module: `pipe_interlock_ctrl`

## Requirements
- R1: After reset the pipeline record is empty. With any Decode operands and any remaining-cycle count, `fetch_en` and `dec_en` are 1, `alu_hold` is 0, and both selects are 0 (register file).
- R2: Select encoding: 0 register file, 1 ALU result, 2 LS1 word-load data, 3 LS2 extended data. A match counts only on a register the operand actually reads. The youngest matching stage wins. A non-load producer is forwarded from ALU with no stall, and from LS1 or LS2 when it is further away.
- R3: A full-word load followed at once by a consumer of its destination stalls the consumer exactly one cycle, after which the select is 2. With one or more instructions between them there is no stall.
- R4: A byte or halfword load stalls an adjacent consumer two cycles, and a consumer with one instruction between them one cycle; the select is then 3. With two or more instructions between them there is no stall.
- R5: In every load-use stall cycle `fetch_en` and `dec_en` are 0 and `alu_bubble` is 1, so the number of bubble cycles equals the number of stall cycles.
- R6: A producer that does not write a register (for example a store), or a Decode slot with `dec_valid` 0, never causes a stall and never selects a forwarding path, whatever its destination field holds.
- R7: An operand whose read flag is 0 never stalls and always has select 0, even when its register field matches a pending load.
- R8: While ALU holds a valid instruction and `alu_cycles_left` is greater than 1, `alu_hold` is 1, `fetch_en` and `dec_en` are 0, and no bubble is inserted. A count of N therefore holds for N-1 cycles, and when ALU is empty the count is ignored.
- R9: `br_taken` with a valid, non-held instruction in ALU raises `flush_fetch` and `flush_dec`, keeps `fetch_en` and `dec_en` at 1, and inserts a bubble. The discarded Decode instruction never becomes a producer. `br_taken` with ALU empty has no effect.
- R10: A flush takes priority over a concurrent load-use stall: `dec_en` stays 1 and the flush strobes are raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | Decode holds a real instruction |
| dec_wr | input | 1 | Decode instruction writes a register |
| dec_dst | input | REG_W | Destination register of the Decode instruction |
| dec_load | input | 1 | Decode instruction is a load |
| dec_narrow | input | 1 | That load is byte or halfword |
| dec_rd_a | input | 1 | Operand A reads a register |
| dec_src_a | input | REG_W | Operand A register |
| dec_rd_b | input | 1 | Operand B reads a register |
| dec_src_b | input | REG_W | Operand B register |
| alu_cycles_left | input | CNT_W | Remaining ALU cycles of the instruction in ALU |
| br_taken | input | 1 | Branch in ALU resolved taken |
| fetch_en | output | 1 | Fetch register may advance |
| dec_en | output | 1 | Decode register may advance |
| alu_bubble | output | 1 | Load an empty slot into ALU |
| alu_hold | output | 1 | ALU keeps its instruction |
| flush_fetch | output | 1 | Invalidate the Fetch slot |
| flush_dec | output | 1 | Invalidate the Decode slot |
| fwd_sel_a | output | 2 | Operand A source select |
| fwd_sel_b | output | 2 | Operand B source select |

## Verification
The bound checker checks these rules on every cycle: a frozen front end without an ALU hold always comes with a bubble, a hold never coincides with a bubble or a flush, a flush always lets Decode advance, and an unread operand always selects the register file. The actual lengths of the stalls, which depend on the load width and on how many instructions lie between producer and consumer, appear only in the bench sweep. So do the select seen when the consumer finally issues, the discarding of a flushed instruction and the length of a multi-cycle hold.

// File: rtl/pil_pkg.sv
package pil_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'd0,
    FWD_ALU = 2'd1,
    FWD_LS1 = 2'd2,
    FWD_LS2 = 2'd3
  } fwd_sel_e;
endpackage

// File: rtl/pil_stage_track.sv
// Records the register-writing attributes of the instructions in ALU, LS1, LS2.
module pil_stage_track #(
  parameter int REG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alu_load,
  input  logic             alu_fill,
  input  logic             in_wr,
  input  logic             in_ld,
  input  logic             in_nr,
  input  logic [REG_W-1:0] in_dst,
  output logic             alu_v,
  output logic             alu_wr,
  output logic             alu_ld,
  output logic             alu_nr,
  output logic [REG_W-1:0] alu_dst,
  output logic             ls1_v,
  output logic             ls1_wr,
  output logic             ls1_ld,
  output logic             ls1_nr,
  output logic [REG_W-1:0] ls1_dst,
  output logic             ls2_v,
  output logic             ls2_wr,
  output logic [REG_W-1:0] ls2_dst
);
  logic alu_v_n, ls1_v_n;

  // next-state: held ALU instruction leaves a hole behind it in LS1
  always_comb begin
    alu_v_n = alu_load ? alu_fill : alu_v;
    ls1_v_n = alu_load ? alu_v : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alu_v   <= 1'b0;
      alu_wr  <= 1'b0;
      alu_ld  <= 1'b0;
      alu_nr  <= 1'b0;
      alu_dst <= '0;
    end else begin
      alu_v <= alu_v_n;
      if (alu_load) begin
        alu_wr  <= in_wr;
        alu_ld  <= in_ld;
        alu_nr  <= in_nr;
        alu_dst <= in_dst;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ls1_v   <= 1'b0;
      ls1_wr  <= 1'b0;
      ls1_ld  <= 1'b0;
      ls1_nr  <= 1'b0;
      ls1_dst <= '0;
      ls2_v   <= 1'b0;
      ls2_wr  <= 1'b0;
      ls2_dst <= '0;
    end else begin
      ls1_v   <= ls1_v_n;
      ls1_wr  <= alu_wr;
      ls1_ld  <= alu_ld;
      ls1_nr  <= alu_nr;
      ls1_dst <= alu_dst;
      ls2_v   <= ls1_v;
      ls2_wr  <= ls1_wr;
      ls2_dst <= ls1_dst;
    end
  end
endmodule

// File: rtl/pil_hazard_unit.sv
// Per-operand dependency check: stall request and forwarding select.
module pil_hazard_unit
  import pil_pkg::*;
#(
  parameter int REG_W = 4
) (
  input  logic             rd,
  input  logic [REG_W-1:0] src,
  input  logic             alu_w,
  input  logic [REG_W-1:0] alu_dst,
  input  logic             alu_ld,
  input  logic             ls1_w,
  input  logic [REG_W-1:0] ls1_dst,
  input  logic             ls1_slow,
  input  logic             ls2_w,
  input  logic [REG_W-1:0] ls2_dst,
  output logic             hz,
  output fwd_sel_e         sel
);
  logic m_alu, m_ls1, m_ls2;

  always_comb begin
    m_alu = rd && alu_w && (alu_dst == src);
    m_ls1 = rd && ls1_w && (ls1_dst == src);
    m_ls2 = rd && ls2_w && (ls2_dst == src);
    hz    = 1'b0;
    sel   = FWD_RF;
    // youngest producer first; a not-yet-ready one forces a stall
    if (m_alu) begin
      if (alu_ld) hz = 1'b1;
      else        sel = FWD_ALU;
    end else if (m_ls1) begin
      if (ls1_slow) hz = 1'b1;
      else          sel = FWD_LS1;
    end else if (m_ls2) begin
      sel = FWD_LS2;
    end
  end
endmodule

// File: rtl/pipe_interlock_ctrl.sv
module pipe_interlock_ctrl
  import pil_pkg::*;
#(
  parameter int REG_W = 4,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_valid,
  input  logic             dec_wr,
  input  logic [REG_W-1:0] dec_dst,
  input  logic             dec_load,
  input  logic             dec_narrow,
  input  logic             dec_rd_a,
  input  logic [REG_W-1:0] dec_src_a,
  input  logic             dec_rd_b,
  input  logic [REG_W-1:0] dec_src_b,
  input  logic [CNT_W-1:0] alu_cycles_left,
  input  logic             br_taken,
  output logic             fetch_en,
  output logic             dec_en,
  output logic             alu_bubble,
  output logic             alu_hold,
  output logic             flush_fetch,
  output logic             flush_dec,
  output logic [1:0]       fwd_sel_a,
  output logic [1:0]       fwd_sel_b
);
  localparam int N_OPND = 2;
  localparam logic [CNT_W-1:0] LAST_CYC = CNT_W'(1);

  logic             alu_v, alu_wr, alu_ld, alu_nr;
  logic             ls1_v, ls1_wr, ls1_ld, ls1_nr;
  logic             ls2_v, ls2_wr;
  logic [REG_W-1:0] alu_dst, ls1_dst, ls2_dst;
  logic             alu_w, ls1_w, ls2_w, ls1_slow;

  logic [N_OPND-1:0] op_rd, op_hz;
  logic [REG_W-1:0]  op_src [N_OPND];
  fwd_sel_e          op_sel [N_OPND];

  logic hold, flush, lu_stall, fill;

  assign alu_w    = alu_v && alu_wr;
  assign ls1_w    = ls1_v && ls1_wr;
  assign ls2_w    = ls2_v && ls2_wr;
  assign ls1_slow = ls1_ld && ls1_nr;

  assign op_rd     = {dec_rd_b, dec_rd_a};
  assign op_src[0] = dec_src_a;
  assign op_src[1] = dec_src_b;

  generate
    for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
      pil_hazard_unit #(.REG_W(REG_W)) u_hz (
        .rd       (op_rd[g]),
        .src      (op_src[g]),
        .alu_w    (alu_w),
        .alu_dst  (alu_dst),
        .alu_ld   (alu_ld),
        .ls1_w    (ls1_w),
        .ls1_dst  (ls1_dst),
        .ls1_slow (ls1_slow),
        .ls2_w    (ls2_w),
        .ls2_dst  (ls2_dst),
        .hz       (op_hz[g]),
        .sel      (op_sel[g])
      );
    end
  endgenerate

  // flow control: hold > flush > load-use stall
  always_comb begin
    hold        = alu_v && (alu_cycles_left > LAST_CYC);
    flush       = br_taken && alu_v && !hold;
    lu_stall    = dec_valid && (|op_hz) && !hold && !flush;
    fill        = dec_valid && !lu_stall && !flush;
    fetch_en    = !hold && !lu_stall;
    dec_en      = !hold && !lu_stall;
    alu_bubble  = !hold && (lu_stall || flush);
    alu_hold    = hold;
    flush_fetch = flush;
    flush_dec   = flush;
    fwd_sel_a   = op_sel[0];
    fwd_sel_b   = op_sel[1];
  end

  pil_stage_track #(.REG_W(REG_W)) u_trk (
    .clk      (clk),
    .rst_n    (rst_n),
    .alu_load (!hold),
    .alu_fill (fill),
    .in_wr    (dec_wr),
    .in_ld    (dec_load),
    .in_nr    (dec_narrow),
    .in_dst   (dec_dst),
    .alu_v    (alu_v),
    .alu_wr   (alu_wr),
    .alu_ld   (alu_ld),
    .alu_nr   (alu_nr),
    .alu_dst  (alu_dst),
    .ls1_v    (ls1_v),
    .ls1_wr   (ls1_wr),
    .ls1_ld   (ls1_ld),
    .ls1_nr   (ls1_nr),
    .ls1_dst  (ls1_dst),
    .ls2_v    (ls2_v),
    .ls2_wr   (ls2_wr),
    .ls2_dst  (ls2_dst)
  );
endmodule

// File: rtl/pil_checker.sv
module pil_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       dec_rd_a,
  input logic       dec_rd_b,
  input logic       fetch_en,
  input logic       dec_en,
  input logic       alu_bubble,
  input logic       alu_hold,
  input logic       flush_fetch,
  input logic       flush_dec,
  input logic [1:0] fwd_sel_a,
  input logic [1:0] fwd_sel_b
);
  assert_stall_bubbles_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_en && !alu_hold) |-> (alu_bubble && !fetch_en));

  assert_hold_freezes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    alu_hold |-> (!fetch_en && !dec_en && !alu_bubble && !flush_dec));

  assert_bubble_clears_alu_R8: assert property (@(posedge clk) disable iff (!rst_n)
    alu_bubble |=> !alu_hold);

  assert_flush_refetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_fetch |-> (fetch_en && alu_bubble && flush_dec));

  assert_flush_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_dec |-> dec_en);

  assert_unread_a_rf_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_rd_a |-> (fwd_sel_a == 2'd0));

  assert_unread_b_rf_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_rd_b |-> (fwd_sel_b == 2'd0));
endmodule

bind pipe_interlock_ctrl pil_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .dec_rd_a    (dec_rd_a),
  .dec_rd_b    (dec_rd_b),
  .fetch_en    (fetch_en),
  .dec_en      (dec_en),
  .alu_bubble  (alu_bubble),
  .alu_hold    (alu_hold),
  .flush_fetch (flush_fetch),
  .flush_dec   (flush_dec),
  .fwd_sel_a   (fwd_sel_a),
  .fwd_sel_b   (fwd_sel_b)
);

// File: tb/pipe_interlock_ctrl_bench.sv
`timescale 1ns/100ps
module pipe_interlock_ctrl_bench;
  localparam int REG_W = 4;
  localparam int CNT_W = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic dec_valid, dec_wr, dec_load, dec_narrow, dec_rd_a, dec_rd_b, br_taken;
  logic [REG_W-1:0] dec_dst, dec_src_a, dec_src_b;
  logic [CNT_W-1:0] alu_cycles_left;
  logic fetch_en, dec_en, alu_bubble, alu_hold, flush_fetch, flush_dec;
  logic [1:0] fwd_sel_a, fwd_sel_b;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  pipe_interlock_ctrl #(.REG_W(REG_W), .CNT_W(CNT_W)) u_pipe_interlock_ctrl (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_wr(dec_wr),
    .dec_dst(dec_dst), .dec_load(dec_load), .dec_narrow(dec_narrow),
    .dec_rd_a(dec_rd_a), .dec_src_a(dec_src_a), .dec_rd_b(dec_rd_b),
    .dec_src_b(dec_src_b), .alu_cycles_left(alu_cycles_left),
    .br_taken(br_taken), .fetch_en(fetch_en), .dec_en(dec_en),
    .alu_bubble(alu_bubble), .alu_hold(alu_hold), .flush_fetch(flush_fetch),
    .flush_dec(flush_dec), .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_ins(input logic v, input logic wr, input int dst,
                         input logic ld, input logic nr,
                         input logic ra, input int sa, input logic rb, input int sb);
    dec_valid = v; dec_wr = wr; dec_dst = REG_W'(dst);
    dec_load = ld; dec_narrow = nr;
    dec_rd_a = ra; dec_src_a = REG_W'(sa);
    dec_rd_b = rb; dec_src_b = REG_W'(sb);
  endtask

  // kinds: 0 alu op, 1 word load, 2 narrow load, 3 store, 4 empty slot, 5 filler
  task automatic drive_kind(input int kind);
    case (kind)
      0: set_ins(1, 1, 5, 0, 0, 1, 1, 1, 2);
      1: set_ins(1, 1, 5, 1, 0, 1, 1, 0, 0);
      2: set_ins(1, 1, 5, 1, 1, 1, 1, 0, 0);
      3: set_ins(1, 0, 5, 0, 0, 1, 1, 1, 2);
      4: set_ins(0, 1, 5, 1, 1, 0, 0, 0, 0);
      default: set_ins(1, 1, 9, 0, 0, 1, 1, 1, 2);
    endcase
  endtask

  task automatic drain();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      set_ins(0, 0, 0, 0, 0, 0, 0, 0, 0);
      br_taken = 1'b0;
      alu_cycles_left = '0;
    end
  endtask

  // mode 0: no match, 1: match, 2: match on an unread operand
  task automatic run_pair(input int ptype, input int gap, input int opb, input int mode);
    int n, idx, stalls, bubs, guard, need, d, st, pos, exp_sel, sel_t, sel_o;
    bit hz;
    drain();
    n = gap + 2; idx = 0; stalls = 0; bubs = 0; guard = 0; sel_t = 0; sel_o = 0;
    while (idx < n && guard < 30) begin
      guard++;
      @(negedge clk);
      if (idx == 0) drive_kind(ptype);
      else if (idx < n - 1) drive_kind(5);
      else begin
        if (opb == 0) set_ins(1, 1, 10, 0, 0, (mode != 2), (mode != 0) ? 5 : 6, 1, 3);
        else          set_ins(1, 1, 10, 0, 0, 1, 3, (mode != 2), (mode != 0) ? 5 : 6);
      end
      #1;
      if (idx == n - 1) begin
        if (!dec_en) begin stalls++; bubs += int'(alu_bubble); end
        sel_t = (opb == 0) ? int'(fwd_sel_a) : int'(fwd_sel_b);
        sel_o = (opb == 0) ? int'(fwd_sel_b) : int'(fwd_sel_a);
      end
      if (dec_en) idx++;
    end
    case (ptype)
      0: need = 1; 1: need = 2; 2: need = 3; default: need = 0;
    endcase
    d = gap + 1;
    hz = (mode == 1) && (need > 0);
    st = (hz && need > d) ? need - d : 0;
    pos = d + st;
    exp_sel = (hz && pos <= 3) ? pos : 0;
    case (ptype)
      0: begin check("R2 stall", stalls, st); check("R2 select", sel_t, exp_sel); end
      1: begin check("R3 stall", stalls, st); check("R3 select", sel_t, exp_sel); end
      2: begin check("R4 stall", stalls, st); check("R4 select", sel_t, exp_sel); end
      default: begin check("R6 stall", stalls, st); check("R6 select", sel_t, exp_sel); end
    endcase
    if (mode == 2) check("R7 unread operand select", sel_t, 0);
    check("R2 other operand select", sel_o, 0);
    check("R5 bubble per stall", bubs, st);
    check("R2 run completed", idx, n);
  endtask

  task automatic run_multi(input int cnt);
    int holds;
    holds = 0;
    drain();
    @(negedge clk); drive_kind(0);
    for (int k = 0; k < cnt; k++) begin
      @(negedge clk);
      set_ins(1, 1, 10, 0, 0, 1, 5, 0, 0);
      alu_cycles_left = CNT_W'(cnt - k);
      #1;
      if (cnt - k > 1) begin
        holds += int'(alu_hold);
        check("R8 front end frozen", int'(dec_en || fetch_en), 0);
        check("R8 no bubble while held", int'(alu_bubble), 0);
      end else begin
        check("R8 released", int'(dec_en && !alu_hold), 1);
        check("R8 forward from ALU on release", int'(fwd_sel_a), 1);
      end
    end
    check("R8 hold cycles", holds, cnt - 1);
  endtask

  initial begin
    #(200000 * 5);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    br_taken = 1'b0;
    alu_cycles_left = '0;
    set_ins(0, 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    @(negedge clk);
    set_ins(1, 1, 5, 0, 0, 1, 0, 1, 0);
    alu_cycles_left = CNT_W'(3);
    #1;
    check("R1 fetch_en", int'(fetch_en), 1);
    check("R1 dec_en", int'(dec_en), 1);
    check("R1 alu_hold", int'(alu_hold), 0);
    check("R1 select a", int'(fwd_sel_a), 0);
    check("R1 select b", int'(fwd_sel_b), 0);

    for (int p = 0; p < 5; p++)
      for (int g = 0; g < 4; g++)
        for (int o = 0; o < 2; o++)
          for (int m = 0; m < 3; m++)
            run_pair(p, g, o, m);

    for (int c = 1; c <= 4; c++) run_multi(c);

    // R9: branch with empty ALU does nothing
    drain();
    @(negedge clk); br_taken = 1'b1; #1;
    check("R9 no flush with empty ALU", int'(flush_dec || flush_fetch || alu_bubble), 0);

    // R9: taken branch flushes and discards Decode
    drain();
    @(negedge clk); set_ins(1, 0, 0, 0, 0, 1, 1, 0, 0);
    @(negedge clk); set_ins(1, 1, 7, 1, 0, 1, 1, 0, 0); br_taken = 1'b1; #1;
    check("R9 flush strobes", int'(flush_fetch && flush_dec), 1);
    check("R9 fetch and decode advance", int'(fetch_en && dec_en), 1);
    check("R9 bubble inserted", int'(alu_bubble), 1);
    @(negedge clk); br_taken = 1'b0; set_ins(1, 1, 10, 0, 0, 1, 7, 0, 0); #1;
    check("R9 flushed load is not a producer (dec_en)", int'(dec_en), 1);
    check("R9 flushed load is not a producer (select)", int'(fwd_sel_a), 0);

    // R10: flush beats a narrow-load stall; contrast without the branch
    for (int t = 0; t < 2; t++) begin
      drain();
      @(negedge clk); drive_kind(2);
      @(negedge clk); set_ins(1, 0, 0, 0, 0, 1, 1, 0, 0);
      @(negedge clk); set_ins(1, 1, 10, 0, 0, 1, 5, 0, 0); br_taken = (t == 0); #1;
      if (t == 0) begin
        check("R10 decode advances under flush", int'(dec_en), 1);
        check("R10 flush raised", int'(flush_dec), 1);
      end else begin
        check("R4 stall from LS1 narrow load", int'(dec_en), 0);
        check("R5 bubble during stall", int'(alu_bubble), 1);
      end
    end

    drain();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule